// File: doc/BRIEF.md
# Calendar register commit bridge

This block sits between a fast register bus and a slow calendar clock. Software writes the calendar's control word, three alarm words and three time words into a bank of staging registers on the fast clock. None of those writes reaches the calendar until software asks for it. To commit, software writes the key 0xA596 to the update register. The block then carries every staged word into the slow domain together, in a single load. Once the slow side has taken the data, the update register reads back 0x5A69.

The request crosses into the slow domain as a toggle through a two-flop synchronizer. The acknowledge comes back to the fast domain the same way. From the request until the acknowledge returns, the staged words are frozen, so the slow side samples a stable multi-bit value. On the slow side the calendar sees a parallel data bus and a one-cycle load strobe.

Top module: `cal_commit_bridge`

## Requirements
- R1: After reset, the update register (address 0) and all seven staging registers read 0. The slow data bus is 0 and the load strobe is low.
- R2: A write to address k, with k from 1 to 7, stores the data in staging register k while no commit is in flight. Reading address k returns that data. The order is: 1 control, 2 to 4 alarm words, 5 to 7 time words.
- R3: The slow data bus changes only in a cycle where the slow load strobe is high. Staged writes are not visible on it until a commit.
- R4: Writing 0xA596 to address 0 while idle starts a commit. Exactly one slow-cycle load pulse follows, and after it slice k-1 of the slow data bus (bits 32(k-1) up to 32k-1) holds staging register k.
- R5: While a commit is in flight, address 0 reads back 0xA596. Once the slow side has loaded, it reads 0x5A69. This completion is never earlier than two slow-clock periods after the key write.
- R6: A write of any value other than the key to address 0 while idle is stored and read back. It starts no commit and causes no load pulse.
- R7: While a commit is in flight, writes to the staging registers are ignored, and the staged values stay unchanged until completion.
- R8: While a commit is in flight, writes to address 0, including the key, are ignored. A second key therefore yields no second load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Fast-domain active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe; with bus_we_i it marks a write |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | AW (3) | Word address: 0 update register, 1 to 7 staging registers |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Combinational read data for bus_addr_i |
| slow_clk_i | input | 1 | Slow calendar clock |
| slow_rst_ni | input | 1 | Slow-domain active-low asynchronous reset |
| slow_load_o | output | 1 | One-cycle strobe in the slow domain marking a fresh load |
| slow_data_o | output | NREG*DW (224) | Committed words, staging register k in slice k-1 |

## Verification
The write of a staging register takes effect at the fast edge where it is accepted. The bench therefore reads it back combinationally half a fast cycle later.

After a key write, the request passes two slow synchronizer flops. The slow load then registers on the third slow edge. The acknowledge passes two fast flops, and one more fast edge writes the done code. The bench polls address 0 once per fast cycle at the falling edge and records the cycle count. It requires the count to lie at or above two slow periods (14 fast cycles) and inside a bounded window.

The slow bus and the load count are compared only after the done code is seen, because the load precedes the acknowledge. The checks that a write is ignored wait well beyond one full commit latency before they compare.

// File: rtl/cal_commit_pkg.sv
package cal_commit_pkg;
  localparam int unsigned NUM_STAGED = 7;
  localparam int unsigned WORD_W     = 32;
  localparam logic [15:0] COMMIT_KEY = 16'hA596;
  localparam logic [15:0] DONE_CODE  = 16'h5A69;
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic tgl_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], tgl_i};
  end

  assign tgl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank
  import cal_commit_pkg::*;
#(
  parameter int unsigned DW   = WORD_W,
  parameter int unsigned NREG = NUM_STAGED,
  parameter int unsigned AW   = $clog2(NREG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [AW-1:0]            bus_addr_i,
  input  logic [DW-1:0]            bus_wdata_i,
  output logic [DW-1:0]            bus_rdata_o,
  input  logic                     ack_sync_i,
  output logic                     req_tgl_o,
  output logic [NREG-1:0][DW-1:0]  shadow_o
);
  localparam logic [DW-1:0] KEY_W  = DW'(COMMIT_KEY);
  localparam logic [DW-1:0] DONE_W = DW'(DONE_CODE);

  logic [NREG-1:0][DW-1:0] shadow_q;
  logic [DW-1:0]           upd_q;
  logic                    req_tgl_q, ack_seen_q;
  logic                    busy, ack_evt, wr_ok, upd_wr, key_wr;

  // busy covers the cycle in which the returning ack is recorded
  assign ack_evt = ack_sync_i ^ ack_seen_q;
  assign busy    = (req_tgl_q ^ ack_sync_i) | ack_evt;
  assign wr_ok   = bus_req_i & bus_we_i & ~busy;
  assign upd_wr  = wr_ok && (bus_addr_i == '0);
  assign key_wr  = upd_wr && (bus_wdata_i == KEY_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q      <= '0;
      req_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      ack_seen_q <= ack_sync_i;
      if (ack_evt)     upd_q <= DONE_W;
      else if (upd_wr) upd_q <= bus_wdata_i;
      if (key_wr)      req_tgl_q <= ~req_tgl_q;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                shadow_q[g] <= '0;
      else if (wr_ok && bus_addr_i == AW'(g + 1)) shadow_q[g] <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == '0) bus_rdata_o = upd_q;
    else begin
      for (int i = 0; i < NREG; i++)
        if (bus_addr_i == AW'(i + 1)) bus_rdata_o = shadow_q[i];
    end
  end

  assign req_tgl_o = req_tgl_q;
  assign shadow_o  = shadow_q;

  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(shadow_q));
  a_r5_busy_reads_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> upd_q == KEY_W);
  a_r4_key_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == '0 && bus_wdata_i == KEY_W && !busy) |=> busy);
  a_r8_no_retoggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (req_tgl_q == $past(req_tgl_q)));
endmodule

// File: rtl/cal_slow_capture.sv
module cal_slow_capture #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 7
) (
  input  logic                    slow_clk_i,
  input  logic                    slow_rst_ni,
  input  logic                    req_sync_i,
  input  logic [NREG-1:0][DW-1:0] shadow_i,
  output logic [NREG*DW-1:0]      data_o,
  output logic                    load_o,
  output logic                    ack_tgl_o
);
  logic                    req_seen_q, load_q, ack_q, req_evt;
  logic [NREG-1:0][DW-1:0] data_q;

  assign req_evt = req_sync_i ^ req_seen_q;

  always_ff @(posedge slow_clk_i or negedge slow_rst_ni) begin
    if (!slow_rst_ni) begin
      req_seen_q <= 1'b0;
      load_q     <= 1'b0;
      ack_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      req_seen_q <= req_sync_i;
      load_q     <= req_evt;
      if (req_evt) begin
        data_q <= shadow_i;
        ack_q  <= req_sync_i;
      end
    end
  end

  assign data_o    = data_q;
  assign load_o    = load_q;
  assign ack_tgl_o = ack_q;

  a_r3_data_moves_on_load: assert property (@(posedge slow_clk_i) disable iff (!slow_rst_ni)
    !load_q |-> $stable(data_q));
  a_r4_single_pulse: assert property (@(posedge slow_clk_i) disable iff (!slow_rst_ni)
    load_q |=> !load_q);
endmodule

// File: rtl/cal_commit_bridge.sv
module cal_commit_bridge
  import cal_commit_pkg::*;
#(
  parameter int unsigned DW          = WORD_W,
  parameter int unsigned NREG        = NUM_STAGED,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = $clog2(NREG + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic                 slow_clk_i,
  input  logic                 slow_rst_ni,
  output logic                 slow_load_o,
  output logic [NREG*DW-1:0]   slow_data_o
);
  logic                    req_tgl, req_sync, ack_tgl, ack_sync;
  logic [NREG-1:0][DW-1:0] shadow;

  cal_shadow_bank #(.DW(DW), .NREG(NREG), .AW(AW)) u_bank (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .ack_sync_i(ack_sync), .req_tgl_o(req_tgl), .shadow_o(shadow)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_ni), .tgl_i(req_tgl), .tgl_o(req_sync)
  );

  cal_slow_capture #(.DW(DW), .NREG(NREG)) u_capture (
    .slow_clk_i, .slow_rst_ni, .req_sync_i(req_sync), .shadow_i(shadow),
    .data_o(slow_data_o), .load_o(slow_load_o), .ack_tgl_o(ack_tgl)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i, .rst_ni, .tgl_i(ack_tgl), .tgl_o(ack_sync)
  );
endmodule

// File: tb/cal_commit_bridge_test.sv
module cal_commit_bridge_test;
  localparam int NREG = 7;
  localparam int DW   = 32;
  localparam logic [31:0] KEY  = 32'h0000A596;
  localparam logic [31:0] DONE = 32'h00005A69;

  logic clk = 0, slow_clk = 0, rst_n = 0, slow_rst_n = 0;
  logic req = 0, we = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic slow_load;
  logic [NREG*DW-1:0] slow_data;

  int errors = 0, checks = 0, loads = 0;
  logic [31:0] exp_slow [NREG];

  always #5 clk = ~clk;
  always #35 slow_clk = ~slow_clk;

  cal_commit_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .slow_clk_i(slow_clk), .slow_rst_ni(slow_rst_n),
    .slow_load_o(slow_load), .slow_data_o(slow_data)
  );

  always @(posedge slow_clk) if (slow_load) loads++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic chk_slow(string tag);
    for (int k = 0; k < NREG; k++) chk(tag, slow_data[k*DW +: DW], exp_slow[k]);
  endtask

  function automatic logic [31:0] pat(int p, int k);
    return (32'h0101_0101 * (p + 1)) ^ (32'h1000_0000 * k) ^ (32'(p * 7 + k) << 4);
  endfunction

  task automatic commit_round(int p, bit disturb);
    logic [31:0] v;
    int cyc, l0;
    for (int k = 0; k < NREG; k++) wr(3'(k + 1), pat(p, k));
    for (int k = 0; k < NREG; k++) begin
      rd(3'(k + 1), v); chk("R2 staged readback", v, pat(p, k));
    end
    chk_slow("R3 slow bus unchanged before commit");
    l0 = loads;
    wr(3'd0, KEY);
    cyc = 1;
    if (disturb) begin
      wr(3'd3, 32'hDEAD_BEEF); cyc += 2;
      wr(3'd0, KEY);           cyc += 2;
      rd(3'd3, v); cyc++;
      chk("R7 staged write ignored while busy", v, pat(p, 2));
      rd(3'd0, v); cyc++;
      chk("R5 key readback while busy", v, KEY);
    end
    rd(3'd0, v);
    while (v !== DONE && cyc < 80) begin rd(3'd0, v); cyc++; end
    chk("R5 done code", v, DONE);
    chk("R5 completion not earlier than two slow periods", 32'(cyc >= 14), 1);
    chk("R5 completion within bound", 32'(cyc <= 40), 1);
    for (int k = 0; k < NREG; k++) exp_slow[k] = pat(p, k);
    chk_slow("R4 slow bus holds staged words");
    repeat (60) @(negedge clk);
    chk("R4 R8 exactly one load pulse", 32'(loads - l0), 1);
  endtask

  initial begin
    logic [31:0] v;
    int l0;
    for (int k = 0; k < NREG; k++) exp_slow[k] = '0;
    #103 rst_n = 1; slow_rst_n = 1;
    rd(3'd0, v); chk("R1 update reset", v, 0);
    for (int k = 1; k <= NREG; k++) begin rd(3'(k), v); chk("R1 staged reset", v, 0); end
    chk_slow("R1 slow bus reset");
    chk("R1 no load after reset", 32'(slow_load), 0);
    for (int p = 0; p < 6; p++) commit_round(p, p[0]);
    l0 = loads;
    wr(3'd0, 32'h0000_1234);
    rd(3'd0, v); chk("R6 non-key readback", v, 32'h0000_1234);
    wr(3'd0, 32'h0001_A596);
    rd(3'd0, v); chk("R6 near-key readback", v, 32'h0001_A596);
    wr(3'd1, 32'hCAFE_0001);
    repeat (100) @(negedge clk);
    chk("R6 no load without key", 32'(loads - l0), 0);
    chk_slow("R6 R3 slow bus unchanged");
    rd(3'd0, v); chk("R6 value kept", v, 32'h0001_A596);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule